// File: doc/BRIEF.md
# Interrupt PQ State MMIO Controller

This block holds a two-bit event state for each of a small array of interrupt sources. The high bit (P) means an event is pending: a notification has gone out and has not been retired. The low bit (Q) means another event arrived while P was set. Software reaches each source through its own 4 KB page in an MMIO window. The access type and the offset inside the page pick an atomic operation. Loads return the state as it was just before the access, and most of them also change it. Stores raise a trigger or retire an event (end of interrupt).

Each source has a configuration bit. When the bit is set, that source accepts an end-of-interrupt by store, and it also accepts triggers through a second, trigger-only page. The block produces a one-cycle notification pulse that carries the source index whenever an event has to go on to the routing logic. The block handles one request per cycle. It is always ready, and it answers every request one cycle after accepting it.

Address layout, from LSB to MSB: bits [11:0] are the page offset, bits [SRC_W+11:12] are the source index, and the top bit selects the trigger page.

Top module: `irq_pq_mmio`

## Requirements
- R1: After reset every source holds state 01 (masked), and rsp_valid and ntf_valid are low.
- R2: An 8-byte load (req_size = 3, log2 of the byte count) at main-page offset 0x800 returns the state in rsp_data[1:0], with P in bit 1 and Q in bit 0 and all higher bits zero. The state is unchanged.
- R3: 8-byte loads at main-page offsets 0xC00, 0xD00, 0xE00 and 0xF00 write state 00, 01, 10 and 11 respectively. Each returns the state held before the write.
- R4: A store of any size to main-page offsets 0x000-0x3FF is a trigger. The trigger moves 00 to 10 and emits a notification with the source index. It moves 10 to 11 and keeps 11 at 11, with no notification in either case.
- R5: A trigger on a source in state 01 leaves it at 01 and emits no notification.
- R6: An 8-byte load at main-page offset 0x000 is an end of interrupt and returns the previous state. It moves 10 to 00. It moves 11 to 10 and emits a notification. It leaves 00 and 01 unchanged.
- R7: A store to main-page offset 0x400 performs the R6 transition only when the source's configuration bit is 1. Otherwise it has no effect.
- R8: A store to the trigger page (address top bit 1) is a trigger only when the source's configuration bit is 1. Otherwise it has no effect. A load on the trigger page returns all-ones and changes nothing.
- R9: A load at an unlisted offset, a load whose size is not 8 bytes, a store at an unlisted offset, and any access to a source index at or above NUM_SRC all leave the state unchanged. Such loads return all-ones.
- R10: req_ready is always high. Each accepted request gives exactly one rsp_valid pulse in the following cycle. Stores respond with zero data. A notification appears in the same cycle as the response of the request that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_store_eoi | input | NUM_SRC | Per-source enable for store end-of-interrupt and the trigger page |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | SRC_W+13 | Page select, source index, page offset |
| req_size | input | 2 | log2 of the access size in bytes |
| rsp_valid | output | 1 | Response valid, one cycle after acceptance |
| rsp_data | output | 64 | Load result (previous state or all-ones); zero for stores |
| ntf_valid | output | 1 | Event notification pulse |
| ntf_src | output | SRC_W | Source index of the notification |

## Verification
On every cycle, the assertions check the response timing and the ordering of notifications after responses. They also check that a set load leaves exactly the requested state, that a get load returns the live state and leaves it alone, that malformed loads return all-ones, and that a masked source stays silent when triggered. The full transition tables depend on the starting state and on the per-source configuration bit. Only the bench's sweep shows them: it drives every operation from every starting state on every source, including an out-of-range index. The same applies to the separation between sources and to the gating of store-EOI and trigger-page accesses.

// File: rtl/irq_pq_pkg.sv
// Shared types and the state-transition function of the PQ controller.
// Assumes a two-bit state {P,Q} per source, with P as the MSB.
package irq_pq_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_TRIG,
        OP_EOI,
        OP_GET,
        OP_SET
    } pq_op_e;

    localparam logic [1:0] PQ_RESET = 2'b01;

    typedef struct packed {
        logic [1:0] pq;
        logic       notify;
    } pq_upd_t;

    // Computes the next state and the notify flag for one operation.
    function automatic pq_upd_t pq_step(pq_op_e op, logic [1:0] cur, logic [1:0] setv);
        pq_upd_t r;
        r.pq     = cur;
        r.notify = 1'b0;
        case (op)
            OP_TRIG: begin
                case (cur)
                    2'b00:   begin r.pq = 2'b10; r.notify = 1'b1; end
                    2'b10,
                    2'b11:   r.pq = 2'b11;
                    default: r.pq = cur;
                endcase
            end
            OP_EOI: begin
                case (cur)
                    2'b10:   r.pq = 2'b00;
                    2'b11:   begin r.pq = 2'b10; r.notify = 1'b1; end
                    default: r.pq = cur;
                endcase
            end
            OP_SET:  r.pq = setv;
            default: r.pq = cur;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/irq_pq_decode.sv
// Turns an MMIO request into a PQ operation.
// Assumes the source index has already been range-checked by the caller
// (src_ok), and that cfg_bit is the selected source's configuration bit.
module irq_pq_decode
    import irq_pq_pkg::*;
#(
    parameter int OFF_W = 12
) (
    input  logic             is_write,
    input  logic             trig_page,
    input  logic             src_ok,
    input  logic             cfg_bit,
    input  logic [OFF_W-1:0] offset,
    input  logic [1:0]       size,
    output pq_op_e           op,
    output logic [1:0]       set_val
);

    localparam logic [1:0] SIZE_8B = 2'd3;

    // Classifies the access by page, direction, offset and size.
    always_comb begin
        op      = OP_NONE;
        set_val = offset[9:8];
        if (!src_ok) begin
            op = OP_NONE;
        end else if (trig_page) begin
            if (is_write && cfg_bit) op = OP_TRIG;
        end else if (is_write) begin
            if (offset[11:10] == 2'b00)
                op = OP_TRIG;
            else if (offset == 12'h400 && cfg_bit)
                op = OP_EOI;
        end else if (size == SIZE_8B) begin
            case (offset)
                12'h000: op = OP_EOI;
                12'h800: op = OP_GET;
                12'hC00, 12'hD00,
                12'hE00, 12'hF00: op = OP_SET;
                default: op = OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/irq_pq_state.sv
// Per-source PQ state registers with a single write port.
// Assumes at most one update per cycle; the reset state is masked (01).
module irq_pq_state
    import irq_pq_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int SRC_W  = $clog2(NUM_SRC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 upd_en,
    input  logic [SRC_W-1:0]     upd_src,
    input  logic [1:0]           upd_pq,
    output logic [2*NUM_SRC-1:0] pq_vec
);

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        logic [1:0] pq_q;

        // Holds one source's state; loads it when this source is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pq_q <= PQ_RESET;
            else if (upd_en && upd_src == SRC_W'(g))
                pq_q <= upd_pq;
        end

        assign pq_vec[2*g +: 2] = pq_q;
    end

endmodule

// File: rtl/irq_pq_mmio.sv
// Top of the PQ state MMIO controller: it decodes requests, applies
// atomic read-modify-write updates, and registers the response and
// the notification. Assumes one request per cycle and no response
// backpressure.
module irq_pq_mmio
    import irq_pq_pkg::*;
#(
    parameter int  NUM_SRC = 8,
    localparam int SRC_W   = $clog2(NUM_SRC),
    localparam int OFF_W   = 12,
    localparam int ADDR_W  = OFF_W + SRC_W + 1,
    localparam int DATA_W  = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] cfg_store_eoi,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [1:0]         req_size,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_data,
    output logic               ntf_valid,
    output logic [SRC_W-1:0]   ntf_src
);

    logic [OFF_W-1:0]     offset;
    logic [SRC_W-1:0]     src_idx;
    logic                 trig_page;
    logic                 src_ok;
    logic                 cfg_bit;
    logic [1:0]           cur_pq;
    logic [1:0]           set_val;
    logic [2*NUM_SRC-1:0] pq_vec;
    logic                 accept;
    pq_op_e               op;
    pq_upd_t              upd;

    assign req_ready = 1'b1;
    assign accept    = req_valid && req_ready;
    assign offset    = req_addr[OFF_W-1:0];
    assign src_idx   = req_addr[OFF_W +: SRC_W];
    assign trig_page = req_addr[ADDR_W-1];
    assign src_ok    = {1'b0, src_idx} < (SRC_W+1)'(NUM_SRC);

    // Selects the addressed source's state and configuration bit.
    always_comb begin
        cur_pq  = 2'b00;
        cfg_bit = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src_idx == SRC_W'(i)) begin
                cur_pq  = pq_vec[2*i +: 2];
                cfg_bit = cfg_store_eoi[i];
            end
        end
    end

    irq_pq_decode #(.OFF_W(OFF_W)) u_decode (
        .is_write  (req_write),
        .trig_page (trig_page),
        .src_ok    (src_ok),
        .cfg_bit   (cfg_bit),
        .offset    (offset),
        .size      (req_size),
        .op        (op),
        .set_val   (set_val)
    );

    // Computes the next state of the addressed source.
    always_comb upd = pq_step(op, cur_pq, set_val);

    irq_pq_state #(.NUM_SRC(NUM_SRC)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (accept && op != OP_NONE),
        .upd_src (src_idx),
        .upd_pq  (upd.pq),
        .pq_vec  (pq_vec)
    );

    // Registers the response with the pre-update state or all-ones.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= accept;
            if (accept) begin
                if (req_write)
                    rsp_data <= '0;
                else if (op == OP_NONE)
                    rsp_data <= '1;
                else
                    rsp_data <= DATA_W'(cur_pq);
            end
        end
    end

    // Registers the notification pulse and its source index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ntf_valid <= 1'b0;
            ntf_src   <= '0;
        end else begin
            ntf_valid <= accept && upd.notify;
            if (accept && upd.notify)
                ntf_src <= src_idx;
        end
    end

endmodule

// File: rtl/irq_pq_checker.sv
// Property checker for irq_pq_mmio, attached through bind. It watches
// the ports and the per-source state vector.
module irq_pq_checker #(
    parameter int  NUM_SRC = 8,
    localparam int SRC_W   = $clog2(NUM_SRC),
    localparam int ADDR_W  = SRC_W + 13
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic                 req_write,
    input logic [ADDR_W-1:0]    req_addr,
    input logic [1:0]           req_size,
    input logic                 rsp_valid,
    input logic [63:0]          rsp_data,
    input logic                 ntf_valid,
    input logic [2*NUM_SRC-1:0] pq_vec
);

    logic             acc;
    logic [SRC_W-1:0] r_src;
    logic             r_ok;
    logic [1:0]       r_pq;
    logic [SRC_W-1:0] last_src;
    logic [1:0]       last_pq_now;
    logic             main_ld8;

    assign acc      = req_valid && req_ready;
    assign r_src    = req_addr[12 +: SRC_W];
    assign r_ok     = {1'b0, r_src} < (SRC_W+1)'(NUM_SRC);
    assign main_ld8 = acc && !req_write && !req_addr[ADDR_W-1] && req_size == 2'd3 && r_ok;

    // Remembers the source of the previous request.
    always_ff @(posedge clk) begin
        if (!rst_n) last_src <= '0;
        else if (acc) last_src <= r_src;
    end

    // Looks up the state of the requested source and of the last one.
    always_comb begin
        r_pq        = 2'b00;
        last_pq_now = 2'b00;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (r_src == SRC_W'(i))    r_pq        = pq_vec[2*i +: 2];
            if (last_src == SRC_W'(i)) last_pq_now = pq_vec[2*i +: 2];
        end
    end

    assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> rsp_valid);

    assert_rsp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !rsp_valid);

    assert_ntf_with_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ntf_valid |-> rsp_valid);

    assert_set_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (main_ld8 && req_addr[11:10] == 2'b11 && req_addr[7:0] == 8'h00)
        |=> (last_pq_now == $past(req_addr[9:8])
             && rsp_data == 64'($past(r_pq))));

    assert_get_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (main_ld8 && req_addr[11:0] == 12'h800)
        |=> (rsp_data == 64'($past(r_pq)) && last_pq_now == $past(r_pq)));

    assert_bad_size_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !req_write && req_size != 2'd3) |=> rsp_data == '1);

    assert_masked_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && req_write && r_ok && r_pq == 2'b01)
        |=> (!ntf_valid && last_pq_now == 2'b01));

endmodule

bind irq_pq_mmio irq_pq_checker #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_size  (req_size),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .ntf_valid (ntf_valid),
    .pq_vec    (pq_vec)
);

// File: tb/irq_pq_mmio_tb.sv
// Sweep bench: every operation from every starting state on every source
// index, including one out of range, with the expected results computed
// from the transition tables.
module irq_pq_mmio_tb;

    localparam int NSRC   = 3;
    localparam int SW     = $clog2(NSRC);
    localparam int AW     = SW + 13;
    localparam int NCASES = 13;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] cfg = 3'b101;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic            req_write = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [1:0]      req_size = 2'd3;
    logic            rsp_valid;
    logic [63:0]     rsp_data;
    logic            ntf_valid;
    logic [SW-1:0]   ntf_src;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    logic [63:0] got_d;
    logic        got_rv, got_nv;
    logic [SW-1:0] got_ns;

    always #2.5 clk = ~clk;

    irq_pq_mmio #(.NUM_SRC(NSRC)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_store_eoi(cfg),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .ntf_valid(ntf_valid), .ntf_src(ntf_src)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One request: driven at a falling edge, sampled at the next falling edge.
    task automatic access(input bit w, input bit pg, input int src, input logic [11:0] off, input logic [1:0] sz);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = {pg, SW'(src), off};
        req_size  = sz;
        chk(req_ready === 1'b1, "R10 ready", 64'(req_ready), 64'd1);
        @(negedge clk);
        req_valid = 1'b0;
        got_rv = rsp_valid;
        got_d  = rsp_data;
        got_nv = ntf_valid;
        got_ns = ntf_src;
        chk(got_rv === 1'b1, "R10 rsp_valid", 64'(got_rv), 64'd1);
    endtask

    function automatic logic [1:0] m_trig(input logic [1:0] c);
        case (c)
            2'b00: return 2'b10;
            2'b01: return 2'b01;
            default: return 2'b11;
        endcase
    endfunction

    function automatic logic [1:0] m_eoi(input logic [1:0] c);
        if (c == 2'b10) return 2'b00;
        if (c == 2'b11) return 2'b10;
        return c;
    endfunction

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                checks++;
                $display("FAIL watchdog expired actual=%0d expected<100000", cycles);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: outputs quiet after reset, every source masked
        chk(rsp_valid === 1'b0, "R1 rsp_valid", 64'(rsp_valid), 64'd0);
        chk(ntf_valid === 1'b0, "R1 ntf_valid", 64'(ntf_valid), 64'd0);
        for (int s = 0; s < NSRC; s++) begin
            access(1'b0, 1'b0, s, 12'h800, 2'd3);
            chk(got_d === 64'd1, "R1 reset state", got_d, 64'd1);
        end

        for (int s = 0; s <= NSRC; s++) begin
            for (int init = 0; init < 4; init++) begin
                for (int c = 0; c < NCASES; c++) begin
                    bit         valid_src;
                    bit         cfgb;
                    bit         w, pg, is_ld_ok;
                    logic [11:0] off;
                    logic [1:0]  sz, nxt;
                    bit          exp_n;
                    logic [63:0] exp_d;
                    string       tag;
                    valid_src = (s < NSRC);
                    cfgb      = valid_src ? cfg[s] : 1'b0;

                    // Set the starting state (R3); returned value is irrelevant here.
                    access(1'b0, 1'b0, s, 12'hC00 + 12'(init) * 12'h100, 2'd3);

                    w = 1'b0; pg = 1'b0; off = 12'h000; sz = 2'd3;
                    nxt = 2'(init); exp_n = 1'b0; is_ld_ok = 1'b0; tag = "";
                    case (c)
                        0:  begin w = 1; off = 12'h000; tag = "R4 trig 0x000";
                                  nxt = m_trig(2'(init)); exp_n = (init == 0); end
                        1:  begin w = 1; off = 12'h3F8; sz = 2'd0; tag = "R4 trig 0x3F8";
                                  nxt = m_trig(2'(init)); exp_n = (init == 0); end
                        2:  begin w = 1; off = 12'h400; tag = "R7 store eoi";
                                  if (cfgb) begin nxt = m_eoi(2'(init)); exp_n = (init == 3); end end
                        3:  begin off = 12'h000; tag = "R6 load eoi"; is_ld_ok = 1;
                                  nxt = m_eoi(2'(init)); exp_n = (init == 3); end
                        4:  begin w = 1; pg = 1; off = 12'h123; tag = "R8 trig page store";
                                  if (cfgb) begin nxt = m_trig(2'(init)); exp_n = (init == 0); end end
                        5:  begin pg = 1; off = 12'h800; tag = "R8 trig page load"; end
                        6:  begin off = 12'hC08; tag = "R9 bad offset"; end
                        7:  begin off = 12'h800; sz = 2'd2; tag = "R9 short load"; end
                        8:  begin w = 1; off = 12'h800; tag = "R9 store unlisted"; end
                        default: begin
                                  off = 12'hC00 + 12'(c - 9) * 12'h100; tag = "R3 set load";
                                  is_ld_ok = 1; nxt = 2'(c - 9); end
                    endcase
                    if (!valid_src) begin
                        nxt = 2'(init); exp_n = 0; is_ld_ok = 0;
                        tag = {tag, " R9 bad source"};
                    end
                    if (init == 1 && (c == 0 || c == 1)) tag = {tag, " R5 masked"};
                    exp_d = w ? 64'd0 : (is_ld_ok ? 64'(init) : '1);

                    access(w, pg, s, off, sz);
                    chk(got_d === exp_d, {tag, " rsp"}, got_d, exp_d);
                    chk(got_nv === exp_n, {tag, " notify"}, 64'(got_nv), 64'(exp_n));
                    if (exp_n)
                        chk(got_ns === SW'(s), {tag, " notify src"}, 64'(got_ns), 64'(s));

                    // R2: read back without side effect, twice
                    access(1'b0, 1'b0, s, 12'h800, 2'd3);
                    exp_d = valid_src ? 64'(nxt) : '1;
                    chk(got_d === exp_d, {tag, " R2 get after"}, got_d, exp_d);
                    if (c == 0 && valid_src) begin
                        access(1'b0, 1'b0, s, 12'h800, 2'd3);
                        chk(got_d === exp_d, "R2 get stable", got_d, exp_d);
                    end
                end
            end
        end

        // R10: no response after an idle cycle
        @(negedge clk);
        chk(rsp_valid === 1'b0, "R10 idle rsp", 64'(rsp_valid), 64'd0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule